// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one shared shift register holding the outcomes of the most recent branches, whatever their addresses. It also keeps a table of 2-bit saturating counters. The counter for a branch is picked by an index built from the branch address and that shared history. A parameter picks how the index is built. In XOR mode, k address bits are XORed with k history bits, where k is the log2 of the table depth. In concatenation mode, a few address bits are placed above the most recent outcomes.

A fetch unit offers a branch address on the lookup stream. One cycle later the block returns the predicted direction and the table index it used. The response is held in a single register. While that register is full and the consumer holds ready low, no new lookup is accepted, so back-pressure travels straight back to the lookup side. The execute stage reports each resolved branch on the update stream. The update port is always ready. Each update trains the counter selected by the update address and the history as it stood before the update. The outcome then enters the history. The two low address bits are ignored, because instructions are 4-byte aligned.

Top module: `ghist_dir_pred`

## Requirements
- R1: After reset the history is all zeros, every counter holds 1 (weakly not-taken), rsp_valid is 0 and lk_ready is 1, so the first lookup predicts not-taken.
- R2: Each counter is 2 bits. It predicts taken in states 2 and 3, counts up on a taken update, counts down on a not-taken update, and saturates at 3 and 0.
- R3: Each accepted update shifts the history left by one bit and places the outcome (1 = taken) in bit 0, so bit 0 is the newest outcome and the top bit is the oldest. Without an update, the history keeps its value.
- R4: An update trains the counter at the index computed from its address and the history before that update's shift.
- R5: In XOR mode the index is (pc >> 2)[k-1:0] XOR history[k-1:0].
- R6: In concatenation mode with 4 address bits and k = 8, the index is {(pc >> 2)[3:0], history[3:0]}, address bits in index bits 7:4.
- R7: The four address/history pairs (0x00,0x01), (0x00,0x00), (0xFF,0x00) and (0xFF,0x80) give four distinct indexes in XOR mode. The last two collide in concatenation mode.
- R8: A lookup is accepted when lk_valid and lk_ready are both high. Its response appears on the next cycle. The response stays stable while rsp_valid is high and rsp_ready is low, and lk_ready is low during that time. A lookup can be accepted in the same cycle that the held response is taken.
- R9: When a lookup and an update are accepted in the same cycle, the lookup sees the counters and history as they were before that update.
- R10: up_ready is always high, so every update with up_valid high is accepted.
- R11: Address bits 1:0 have no effect on the index or the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high |
| lk_pc | input | PC_W | Branch address to predict |
| rsp_valid | output | 1 | Prediction response valid |
| rsp_ready | input | 1 | Consumer ready for the response |
| rsp_taken | output | 1 | Predicted direction, 1 = taken |
| rsp_idx | output | IDX_W | Table index used for the prediction |
| up_valid | input | 1 | Resolved branch valid |
| up_ready | output | 1 | Update accepted (always high) |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench builds two copies of the block, each with a 32-bit address, a 256-entry table (k = 8) and 2 address bits dropped. One copy uses XOR mode and the other uses concatenation mode with 4 address bits. Both copies receive the same streams. This lets one history setup show the XOR indexes staying apart while the concatenated indexes collide. With a table that small, a few hundred updates are enough to drive counters into both saturation limits. The same updates also drive several addresses onto shared entries under repeating patterns such as (TN)*, (TTNN)* and (TTTN)*.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

  typedef logic [1:0] ctr2_t;

  typedef enum logic {
    IDX_XOR = 1'b0,
    IDX_CAT = 1'b1
  } idx_mode_e;

  localparam ctr2_t CTR_INIT = 2'd1;

  function automatic ctr2_t ctr_step(input ctr2_t c, input logic taken);
    ctr2_t n;
    if (taken) n = (c == 2'd3) ? c : c + 2'd1;
    else       n = (c == 2'd0) ? c : c - 2'd1;
    return n;
  endfunction

  function automatic logic ctr_dir(input ctr2_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/gsp_index.sv
module gsp_index #(
  parameter int                  PC_W        = 32,
  parameter int                  IDX_W       = 8,
  parameter int                  PC_DROP     = 2,
  parameter int                  CAT_PC_BITS = 4,
  parameter gsp_pkg::idx_mode_e  MODE        = gsp_pkg::IDX_XOR
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [IDX_W-1:0] hist,
  output logic [IDX_W-1:0] idx
);
  localparam int CAT_H_BITS = IDX_W - CAT_PC_BITS;

  logic [PC_W-1:0] pc_sh;
  assign pc_sh = pc >> PC_DROP;

  generate
    if (MODE == gsp_pkg::IDX_XOR) begin : g_xor
      logic unused_pc_hi;
      assign unused_pc_hi = ^pc_sh[PC_W-1:IDX_W];
      assign idx = pc_sh[IDX_W-1:0] ^ hist;
    end else begin : g_cat
      logic unused_bits;
      assign unused_bits = ^{pc_sh[PC_W-1:CAT_PC_BITS], hist[IDX_W-1:CAT_H_BITS]};
      assign idx = {pc_sh[CAT_PC_BITS-1:0], hist[CAT_H_BITS-1:0]};
    end
  endgenerate

endmodule

// File: rtl/gsp_hist.sv
module gsp_hist #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[W-2:0], bit_in};
  end

  // R3: history holds when no update is accepted
  a_r3_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));

  // R3: newest outcome lands in bit 0
  a_r3_newest_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist[0] == $past(bit_in));

endmodule

// File: rtl/gsp_table.sv
module gsp_table #(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output gsp_pkg::ctr2_t     rd_ctr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_taken
);
  import gsp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  assign rd_ctr = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_taken);
    end
  end

  // R2: saturates at the top
  a_r2_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && mem[wr_idx] == 2'd3) |=> mem[$past(wr_idx)] == 2'd3);

  // R2: saturates at the bottom
  a_r2_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && mem[wr_idx] == 2'd0) |=> mem[$past(wr_idx)] == 2'd0);

endmodule

// File: rtl/ghist_dir_pred.sv
module ghist_dir_pred #(
  parameter int                  PC_W        = 32,
  parameter int                  IDX_W       = 8,
  parameter int                  PC_DROP     = 2,
  parameter int                  CAT_PC_BITS = 4,
  parameter gsp_pkg::idx_mode_e  MODE        = gsp_pkg::IDX_XOR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_taken,
  output logic [IDX_W-1:0] rsp_idx,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PC_W-1:0]  up_pc,
  input  logic             up_taken
);
  import gsp_pkg::*;

  logic [IDX_W-1:0] hist;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  ctr2_t            lk_ctr;
  logic             lk_fire;
  logic             up_fire;

  assign up_ready = 1'b1;
  assign up_fire  = up_valid;
  assign lk_ready = !rsp_valid || rsp_ready;
  assign lk_fire  = lk_valid && lk_ready;

  gsp_index #(
    .PC_W(PC_W), .IDX_W(IDX_W), .PC_DROP(PC_DROP),
    .CAT_PC_BITS(CAT_PC_BITS), .MODE(MODE)
  ) u_lk_index (
    .pc(lk_pc), .hist(hist), .idx(lk_idx)
  );

  gsp_index #(
    .PC_W(PC_W), .IDX_W(IDX_W), .PC_DROP(PC_DROP),
    .CAT_PC_BITS(CAT_PC_BITS), .MODE(MODE)
  ) u_up_index (
    .pc(up_pc), .hist(hist), .idx(up_idx)
  );

  gsp_hist #(.W(IDX_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(up_fire),
    .bit_in(up_taken), .hist(hist)
  );

  gsp_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_ctr(lk_ctr),
    .wr_en(up_fire), .wr_idx(up_idx), .wr_taken(up_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_taken <= 1'b0;
      rsp_idx   <= '0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_taken <= ctr_dir(lk_ctr);
      rsp_idx   <= lk_idx;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8: a stalled response is held unchanged
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_taken) && $stable(rsp_idx));

  // R8: no new lookup is taken while the response is stalled
  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lk_ready);

  // R8: an accepted lookup yields a response next cycle
  a_r8_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

endmodule

// File: tb/tb_ghist_dir_pred.sv
`timescale 1ns/1ps
module tb_ghist_dir_pred;
  import gsp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        rsp_ready = 1'b1;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;

  logic       x_lk_ready, x_rsp_valid, x_rsp_taken, x_up_ready;
  logic [7:0] x_rsp_idx;
  logic       s_lk_ready, s_rsp_valid, s_rsp_taken, s_up_ready;
  logic [7:0] s_rsp_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          m_x [256];
  int          m_s [256];
  logic [7:0]  m_hist;

  always #2.5 clk = ~clk;

  ghist_dir_pred #(.PC_W(32), .IDX_W(8), .PC_DROP(2), .CAT_PC_BITS(4),
                   .MODE(IDX_XOR)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(x_lk_ready),
    .lk_pc(lk_pc), .rsp_valid(x_rsp_valid), .rsp_ready(rsp_ready),
    .rsp_taken(x_rsp_taken), .rsp_idx(x_rsp_idx), .up_valid(up_valid),
    .up_ready(x_up_ready), .up_pc(up_pc), .up_taken(up_taken));

  ghist_dir_pred #(.PC_W(32), .IDX_W(8), .PC_DROP(2), .CAT_PC_BITS(4),
                   .MODE(IDX_CAT)) dut_gsel (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(s_lk_ready),
    .lk_pc(lk_pc), .rsp_valid(s_rsp_valid), .rsp_ready(rsp_ready),
    .rsp_taken(s_rsp_taken), .rsp_idx(s_rsp_idx), .up_valid(up_valid),
    .up_ready(s_up_ready), .up_pc(up_pc), .up_taken(up_taken));

  function automatic logic [7:0] f_idx_x(input logic [31:0] pc, input logic [7:0] h);
    logic [31:0] s;
    s = pc >> 2;
    return s[7:0] ^ h;
  endfunction

  function automatic logic [7:0] f_idx_s(input logic [31:0] pc, input logic [7:0] h);
    logic [31:0] s;
    s = pc >> 2;
    return {s[3:0], h[3:0]};
  endfunction

  function automatic int f_step(input int c, input logic t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req,
                       input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_x[i] = 1;
      m_s[i] = 1;
    end
    m_hist = '0;
  endtask

  task automatic model_update(input logic [31:0] pc, input logic t);
    logic [7:0] ix, is;
    ix = f_idx_x(pc, m_hist);
    is = f_idx_s(pc, m_hist);
    m_x[ix] = f_step(m_x[ix], t);
    m_s[is] = f_step(m_s[is], t);
    m_hist = {m_hist[6:0], t};
  endtask

  task automatic check_rsp(input logic [31:0] pc, input string req);
    logic [7:0] ix, is;
    ix = f_idx_x(pc, m_hist);
    is = f_idx_s(pc, m_hist);
    check({31'd0, x_rsp_valid}, 32'd1, req, "xor rsp_valid");
    check({24'd0, x_rsp_idx}, {24'd0, ix}, req, "xor idx");
    check({31'd0, x_rsp_taken}, {31'd0, m_x[ix] >= 2}, req, "xor pred");
    check({24'd0, s_rsp_idx}, {24'd0, is}, req, "cat idx");
    check({31'd0, s_rsp_taken}, {31'd0, m_s[is] >= 2}, req, "cat pred");
  endtask

  task automatic do_lookup(input logic [31:0] pc, input string req);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_pc = pc;
    @(negedge clk);
    lk_valid = 1'b0;
    check_rsp(pc, req);
  endtask

  task automatic do_update(input logic [31:0] pc, input logic t);
    @(negedge clk);
    up_valid = 1'b1;
    up_pc = pc;
    up_taken = t;
    @(negedge clk);
    up_valid = 1'b0;
    model_update(pc, t);
  endtask

  task automatic set_hist(input logic [7:0] h);
    for (int i = 7; i >= 0; i--) do_update(32'h0000_8000, h[i]);
  endtask

  function automatic logic pattern_bit(input int cls, input int n);
    case (cls)
      0: return 1'b1;
      1: return 1'b0;
      2: return (n % 2) == 0;
      3: return (n % 4) < 2;
      4: return (n % 4) != 3;
      default: return $urandom_range(0, 1) == 1;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ids [4];
    logic [7:0] sds [4];
    logic [7:0] hh [4];
    logic [31:0] aa [4];
    int cnt [8];
    logic [31:0] pcs [8];
    logic [31:0] pc0;
    logic [7:0] idx_a;
    logic       tk_a;

    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: reset state at the ports
    check({31'd0, x_rsp_valid}, 32'd0, "R1", "rsp_valid after reset");
    check({31'd0, x_lk_ready}, 32'd1, "R1", "lk_ready after reset");
    check({31'd0, x_up_ready}, 32'd1, "R10", "up_ready");
    do_lookup(32'h0000_1234, "R1");

    // R2: drive one counter up to saturation with history held at all ones
    set_hist(8'hFF);
    for (int i = 0; i < 5; i++) do_update(32'h0000_2000, 1'b1);
    do_lookup(32'h0000_2000, "R2");
    check({31'd0, x_rsp_taken}, 32'd1, "R2", "saturated taken");
    // and down to zero with history held at all zeros
    set_hist(8'h00);
    for (int i = 0; i < 5; i++) do_update(32'h0000_2000, 1'b0);
    do_lookup(32'h0000_2000, "R2");
    check({31'd0, x_rsp_taken}, 32'd0, "R2", "saturated not-taken");

    // R3 / R4: a single taken update moves history, training at old index
    do_update(32'h0000_2000, 1'b1);
    do_lookup(32'h0000_2000, "R3");
    check({24'd0, x_rsp_idx}, {24'd0, 8'h00 ^ 8'h01}, "R3", "history bit0 after taken");
    do_update(32'h0000_2004, 1'b1);
    do_lookup(32'h0000_2004, "R4");

    // R5 / R6 / R7: aliasing pairs
    aa[0] = 32'h000; hh[0] = 8'h01;
    aa[1] = 32'h000; hh[1] = 8'h00;
    aa[2] = 32'h3FC; hh[2] = 8'h00;
    aa[3] = 32'h3FC; hh[3] = 8'h80;
    for (int p = 0; p < 4; p++) begin
      set_hist(hh[p]);
      do_lookup(aa[p], "R5");
      ids[p] = x_rsp_idx;
      sds[p] = s_rsp_idx;
    end
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        check({31'd0, ids[a] != ids[b]}, 32'd1, "R7", "xor indexes distinct");
    check({24'd0, sds[2]}, {24'd0, sds[3]}, "R7", "cat indexes collide");
    check({24'd0, sds[3]}, 32'hF0, "R6", "cat index value");

    // R11: low address bits ignored
    pc0 = 32'h0000_5A10;
    do_lookup(pc0, "R11");
    idx_a = x_rsp_idx;
    tk_a = x_rsp_taken;
    do_lookup(pc0 | 32'h3, "R11");
    check({24'd0, x_rsp_idx}, {24'd0, idx_a}, "R11", "idx with low bits set");
    check({31'd0, x_rsp_taken}, {31'd0, tk_a}, "R11", "pred with low bits set");

    // R8: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    lk_valid = 1'b1;
    lk_pc = 32'h0000_6000;
    @(negedge clk);
    check_rsp(32'h0000_6000, "R8");
    check({31'd0, x_lk_ready}, 32'd0, "R8", "lk_ready low while stalled");
    lk_pc = 32'h0000_6104;
    @(negedge clk);
    @(negedge clk);
    check({24'd0, x_rsp_idx}, {24'd0, f_idx_x(32'h0000_6000, m_hist)}, "R8", "held idx");
    check({31'd0, x_rsp_valid}, 32'd1, "R8", "held valid");
    rsp_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check_rsp(32'h0000_6104, "R8");

    // R9: lookup and update in the same cycle
    set_hist(8'hFF);
    for (int i = 0; i < 3; i++) do_update(32'h0000_7000, 1'b0);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_pc = 32'h0000_7000;
    up_valid = 1'b1;
    up_pc = 32'h0000_7000;
    up_taken = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    up_valid = 1'b0;
    check_rsp(32'h0000_7000, "R9");
    model_update(32'h0000_7000, 1'b1);
    do_lookup(32'h0000_7000, "R9");

    // R2 / R3 / R4 / R5 / R6: periodic and random streams
    for (int j = 0; j < 8; j++) begin
      cnt[j] = 0;
      pcs[j] = 32'h0000_4000 + j * 32'h124;
    end
    for (int s = 0; s < 600; s++) begin
      int j;
      logic t;
      j = $urandom_range(0, 7);
      t = pattern_bit(j % 6, cnt[j]);
      cnt[j]++;
      do_lookup(pcs[j], "R5");
      do_update(pcs[j], t);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule